// File: doc/BRIEF.md
# Adder Result Store Sequencer

This block takes the five-bit outcome of a four-bit addition, a carry bit and a four-bit sum, and stores it in a small external 8-word by 4-bit memory. The memory has an active-low read/write select, an active-high chip-select strobe and an output enable. It writes a word on the rising edge of the chip select while the read/write select is low. The sequencer owns the memory's address, data and control pins for the whole store operation.

A one-cycle `start` pulse while idle copies the carry and sum into internal registers, so the adder may change its outputs at once. The block then performs two write steps, timed by its clock. Memory word 0 receives the carry in its least significant bit, with the three upper bits cleared. Memory word 1 receives the sum. Each step presents the address and data, then lowers the read/write select, then raises chip select for one cycle and drops it for one cycle. The output enable stays inactive throughout. A single-cycle `done` pulse closes the operation. Any `start` seen while a store is under way is discarded.

Top module: `sum_store_seq`

## Requirements
- R1: While reset is held and in the first cycle after its release, `memCs` is 0, `memRwN` is 1, `memOe` is 0 and `done` is 0.
- R2: The carry and sum are sampled on the clock edge where `start` is seen high in the idle state. Changes on `resCarry`/`resSum` after that edge do not alter what is written.
- R3: The first write goes to address 0, with data bit 0 equal to the captured carry and data bits 3 to 1 equal to zero.
- R4: The second write goes to address 1, with data equal to the captured four-bit sum.
- R5: Each write step lasts four cycles: a setup cycle (address and data valid, `memRwN`=1, `memCs`=0), a write-enable cycle (`memRwN`=0, `memCs`=0), a strobe cycle (`memRwN`=0, `memCs`=1) and a release cycle (`memRwN`=0, `memCs`=0). Address and data hold steady across all four cycles.
- R6: `memOe` is 0 in every cycle.
- R7: `done` is 1 for exactly one cycle, the cycle after the second release cycle. That is the ninth cycle after the start edge. The block is idle in the following cycle.
- R8: A `start` pulse during any busy cycle, including the `done` cycle, is ignored. It does not restart the sequence, change the captured values or add strobes.
- R9: Each accepted start produces exactly two `memCs` rising edges, address 0 first, then address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencing clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to store the current result (single-cycle pulse) |
| resCarry | input | 1 | Carry out of the four-bit addition |
| resSum | input | 4 | Sum out of the four-bit addition |
| memAddr | output | 3 | Memory word address |
| memData | output | 4 | Memory write data |
| memRwN | output | 1 | Read/write select, 0 selects write |
| memCs | output | 1 | Chip-select strobe, memory writes on its rising edge |
| memOe | output | 1 | Memory output enable, held inactive (0) |
| done | output | 1 | One-cycle pulse when both words are stored |

## Verification
A phase counter stuck or skipping a state shows up at the memory pins within one cycle. A chip-select pulse that is too long, or that arrives without the write-enable lead cycle, is one example. A wrong word-select bit shows up as the wrong address or data at the next strobe, at most four cycles later. It leaves the model memory holding the carry word at address 1 or the sum at address 0. A capture register that reloads mid-sequence is exposed because the bench flips the adder inputs right after start. Extra start pulses inside a store are used to reveal any restart, which would show as a late `done` or a third strobe.

// File: rtl/sum_store_pkg.sv
package sum_store_pkg;

  // Phase of one write step; the word selector is held separately.
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SETUP   = 3'd1,
    PH_WEN     = 3'd2,
    PH_STROBE  = 3'd3,
    PH_RELEASE = 3'd4,
    PH_FIN     = 3'd5
  } phase_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadRes;   // capture carry and sum
    logic selHigh;   // 0: carry word, 1: sum word
    logic writeLow;  // drive read/write select low
    logic strobe;    // drive chip select high
  } store_ctrl_t;

endpackage

// File: rtl/store_ctrl.sv
module store_ctrl
  import sum_store_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output store_ctrl_t ctrlO,
  output logic        done
);

  phase_e phaseQ;
  logic   highQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      highQ  <= 1'b0;
    end else begin
      unique case (phaseQ)
        PH_IDLE: begin
          if (start) begin
            phaseQ <= PH_SETUP;
            highQ  <= 1'b0;
          end
        end
        PH_SETUP:   phaseQ <= PH_WEN;
        PH_WEN:     phaseQ <= PH_STROBE;
        PH_STROBE:  phaseQ <= PH_RELEASE;
        PH_RELEASE: begin
          if (highQ) begin
            phaseQ <= PH_FIN;
          end else begin
            phaseQ <= PH_SETUP;
            highQ  <= 1'b1;
          end
        end
        PH_FIN:     phaseQ <= PH_IDLE;
        default:    phaseQ <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrlO.loadRes  = (phaseQ == PH_IDLE) && start;
    ctrlO.selHigh  = highQ;
    ctrlO.writeLow = (phaseQ == PH_WEN) || (phaseQ == PH_STROBE) || (phaseQ == PH_RELEASE);
    ctrlO.strobe   = (phaseQ == PH_STROBE);
    done           = (phaseQ == PH_FIN);
  end

  // R7: completion pulse is a single cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: completion follows the strobe of the sum word by two cycles
  assert_done_after_second_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(ctrlO.strobe, 2) && ctrlO.selHigh));

  // R8: a start while busy never enters a fresh carry-word step
  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (start && phaseQ != PH_IDLE) |=> !(phaseQ == PH_SETUP && !highQ));

endmodule

// File: rtl/store_dp.sv
module store_dp
  import sum_store_pkg::*;
#(
  parameter int DATA_W  = 4,
  parameter int ADDR_W  = 3,
  parameter int LO_ADDR = 0,
  parameter int HI_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  store_ctrl_t       ctrlI,
  input  logic              resCarry,
  input  logic [DATA_W-1:0] resSum,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              memRwN,
  output logic              memCs,
  output logic              memOe
);

  localparam logic [ADDR_W-1:0] ADDR_CARRY = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] ADDR_SUM   = ADDR_W'(HI_ADDR);
  localparam int                PAD_W      = DATA_W - 1;

  logic              carryQ;
  logic [DATA_W-1:0] sumQ;
  logic [DATA_W-1:0] carryWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryQ <= 1'b0;
      sumQ   <= '0;
    end else if (ctrlI.loadRes) begin
      carryQ <= resCarry;
      sumQ   <= resSum;
    end
  end

  assign carryWord = {{PAD_W{1'b0}}, carryQ};

  always_comb begin
    memAddr = ctrlI.selHigh ? ADDR_SUM : ADDR_CARRY;
    memData = ctrlI.selHigh ? sumQ : carryWord;
    memRwN  = !ctrlI.writeLow;
    memCs   = ctrlI.strobe;
    memOe   = 1'b0;
  end

  // R5: strobe rises only after a write-enable lead cycle with steady address/data
  assert_strobe_setup_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCs) |-> (!memRwN && $past(!memRwN) && $stable(memAddr) && $stable(memData)));

  // R5: chip-select pulse lasts one cycle
  assert_strobe_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    memCs |=> (!memCs && !memRwN));

  // R2: captured result stays frozen while a write step is active
  assert_capture_frozen_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlI.writeLow || ctrlI.strobe) |=> ($stable(carryQ) && $stable(sumQ)));

endmodule

// File: rtl/sum_store_seq.sv
module sum_store_seq
  import sum_store_pkg::*;
#(
  parameter int DATA_W  = 4,
  parameter int ADDR_W  = 3,
  parameter int LO_ADDR = 0,
  parameter int HI_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              resCarry,
  input  logic [DATA_W-1:0] resSum,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              memRwN,
  output logic              memCs,
  output logic              memOe,
  output logic              done
);

  store_ctrl_t ctrl;

  store_ctrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctrlO (ctrl),
    .done  (done)
  );

  store_dp #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .LO_ADDR (LO_ADDR),
    .HI_ADDR (HI_ADDR)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlI    (ctrl),
    .resCarry (resCarry),
    .resSum   (resSum),
    .memAddr  (memAddr),
    .memData  (memData),
    .memRwN   (memRwN),
    .memCs    (memCs),
    .memOe    (memOe)
  );

  // R6: output enable never active while a write is strobed
  assert_oe_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    memCs |-> !memOe);

endmodule

// File: tb/tb_sum_store_seq.sv
module tb_sum_store_seq;

  logic       clk = 1'b0;
  logic       rstN;
  logic       start;
  logic       resCarry;
  logic [3:0] resSum;
  logic [2:0] memAddr;
  logic [3:0] memData;
  logic       memRwN;
  logic       memCs;
  logic       memOe;
  logic       done;

  int checkCnt = 0;
  int failCnt  = 0;

  logic [3:0] memModel [8];
  int         strobeCnt;
  logic [2:0] writeLog [4];

  always #10 clk = ~clk;

  sum_store_seq dut (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .resCarry (resCarry),
    .resSum   (resSum),
    .memAddr  (memAddr),
    .memData  (memData),
    .memRwN   (memRwN),
    .memCs    (memCs),
    .memOe    (memOe),
    .done     (done)
  );

  // Memory model: writes on chip-select rise while read/write select is low
  always @(posedge memCs) begin
    if (rstN === 1'b1 && memRwN === 1'b0) begin
      memModel[memAddr] = memData;
      if (strobeCnt < 4) writeLog[strobeCnt] = memAddr;
      strobeCnt = strobeCnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int i = 0; i < 8; i++) memModel[i] = 4'hF;
    strobeCnt = 0;
    for (int i = 0; i < 4; i++) writeLog[i] = 3'h7;
  endtask

  // Pins expected at the i-th negedge after the start edge (i = 1..10)
  task automatic checkCycle(input int i, input logic c, input logic [3:0] s);
    logic       w;
    int         ph;
    logic [3:0] expData;
    if (i <= 8) begin
      w  = (i > 4);
      ph = (i - 1) % 4;
      expData = w ? s : {3'b000, c};
      check("R5 memRwN", memRwN, (ph == 0));
      check("R5 memCs",  memCs,  (ph == 2));
      check(w ? "R4 addr" : "R3 addr", memAddr, {2'b00, w});
      check(w ? "R4 data" : "R3 data", memData, expData);
      check("R7 done low", done, 1'b0);
    end else begin
      check("R5 idle memCs", memCs, 1'b0);
      check("R5 idle memRwN", memRwN, 1'b1);
      check("R7 done", done, (i == 9));
    end
    check("R6 memOe", memOe, 1'b0);
  endtask

  task automatic resetTest();
    rstN = 1'b0; start = 1'b0; resCarry = 1'b0; resSum = 4'h0;
    clearModel();
    repeat (3) @(negedge clk);
    check("R1 cs in reset", memCs, 1'b0);
    check("R1 rwn in reset", memRwN, 1'b1);
    check("R1 done in reset", done, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 cs", memCs, 1'b0);
    check("R1 rwn", memRwN, 1'b1);
    check("R1 oe", memOe, 1'b0);
    check("R1 done", done, 1'b0);
  endtask

  // Normal run; inputs are flipped after the start edge (R2)
  task automatic runSeq(input logic c, input logic [3:0] s);
    clearModel();
    resCarry = c; resSum = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    resCarry = ~c; resSum = ~s;
    for (int i = 1; i <= 10; i++) begin
      checkCycle(i, c, s);
      @(negedge clk);
    end
    check("R3 word0", memModel[0], {3'b000, c});
    check("R4 word1 R2", memModel[1], s);
    check("R9 strobes", strobeCnt, 2);
    check("R9 first addr", writeLog[0], 3'd0);
    check("R9 second addr", writeLog[1], 3'd1);
  endtask

  // Start pulses inside a running store must be discarded
  task automatic busyStartTest(input logic c, input logic [3:0] s);
    clearModel();
    resCarry = c; resSum = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= 10; i++) begin
      checkCycle(i, c, s);
      if (i == 3 || i == 6 || i == 9) begin
        start = 1'b1; resCarry = ~c; resSum = ~s;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 no restart cs", memCs, 1'b0);
    check("R8 no extra done", done, 1'b0);
    check("R8 word0", memModel[0], {3'b000, c});
    check("R8 word1", memModel[1], s);
    check("R8 strobes", strobeCnt, 2);
  endtask

  initial begin
    fork
      begin
        resetTest();
        runSeq(1'b0, 4'h0);
        runSeq(1'b1, 4'hF);
        runSeq(1'b1, 4'hA);
        busyStartTest(1'b1, 4'h6);
        runSeq(1'b0, 4'h5);
      end
      begin
        repeat (200000) @(posedge clk);
        failCnt++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

endmodule